// File: doc/BRIEF.md
# H-Bridge Gate Interlock with Latched Shutdown

This block sits between the four switching commands of a two-phase H-bridge (an upper and a lower command for phase A and for phase B) and the four gate enables that drive the bridge transistors. It guarantees that the two transistors of one phase never conduct together. It enforces a programmable dead time between one transistor of a phase turning off and the other turning on. It discards command pulses shorter than a programmable minimum width. It also provides a latched shutdown: an active-high halt input turns every gate off at once and keeps the bridge off until a defined release sequence has completed.

Two state machines carry the behaviour. The lock machine has three states. HALT is entered on reset and whenever the synchronised halt is high. DRAIN is entered from HALT once the synchronised halt reads low. RUN is entered from DRAIN once all four commands are low. Both DRAIN and RUN fall back to HALT when the synchronised halt is high. Each phase has its own leg machine, also with three states. It moves from IDLE to UP or to DN when a qualified, non-conflicting command is present and the dead time allows it. It returns from UP or DN to IDLE as soon as its command drops, the opposite command rises, or the enable is withdrawn. Each phase also reports its output as high, low or high-impedance, so that the bridge state can be checked.

Top module: `hbridge_guard`

## Requirements
- R1: With only the upper command of a phase high, that phase's upper gate is on, its lower gate is off, and its state output reads 2'b10 (high).
- R2: With only the lower command of a phase high, that phase's lower gate is on, its upper gate is off, and its state output reads 2'b01 (low).
- R3: With both commands of a phase high, both gates of that phase are off and the state output reads 2'b00 (high-impedance), in the same cycle even if one gate was on, for as long as the pair stays high.
- R4: With both commands of a phase low, both gates are off and the state reads 2'b00.
- R5: A high halt input turns all four gates off in the same cycle, without waiting for a clock edge, and every command is ignored while it stays high. A halt held across a single clock edge is enough to latch the shutdown.
- R6: After a shutdown, the gates stay off until the two-flop-synchronised halt is low and then all four commands have been low at a clock edge. A command held high across the release never turns its gate on, and a fresh rising command after the release works normally.
- R7: Reset leaves the lock in HALT with all gates off, and the same release sequence as in R6 is needed before any gate turns on.
- R8: When one gate of a phase turns off, the other gate of that phase stays off until DEAD_CYC clock edges have passed. A swap done in a single cycle therefore turns the new gate on at edge max(MIN_PW_CYC+1, DEAD_CYC+2). Turning the same gate back on waits for no dead time.
- R9: A command must be sampled high at MIN_PW_CYC consecutive edges before its gate can turn on. From an idle, unblocked phase, the gate turns on right after edge MIN_PW_CYC+1. A pulse of MIN_PW_CYC cycles or fewer causes no gate activity at all.
- R10: A gate turns off in the same cycle its command drops, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_in | input | 1 | Active-high shutdown request |
| cmd_up_a | input | 1 | Phase A upper transistor command |
| cmd_dn_a | input | 1 | Phase A lower transistor command |
| cmd_up_b | input | 1 | Phase B upper transistor command |
| cmd_dn_b | input | 1 | Phase B lower transistor command |
| gate_up_a | output | 1 | Phase A upper gate enable |
| gate_dn_a | output | 1 | Phase A lower gate enable |
| gate_up_b | output | 1 | Phase B upper gate enable |
| gate_dn_b | output | 1 | Phase B lower gate enable |
| leg_a_state | output | 2 | Phase A output: 10 high, 01 low, 00 high-impedance |
| leg_b_state | output | 2 | Phase B output: 10 high, 01 low, 00 high-impedance |

## Verification
The following properties are checked on every cycle:
- Conflicting or idle command pairs leave the phase at high-impedance.
- A raised halt input leaves every gate off.
- No gate rises before its command has been qualified for the minimum width.
- No gate rises before the opposite gate has been off for the dead time.
- The lock never jumps from HALT, or from DRAIN with a command still high, straight into RUN.

Other behaviours can only be shown by the bench's scenarios:
- The exact turn-on latencies.
- That a command held high across a release stays ignored.
- That a one-cycle halt pulse still latches the shutdown.
- That pulse widths on either side of the threshold give the expected result.
- The full sweep of all sixteen command patterns.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        LK_HALT  = 2'd0,
        LK_DRAIN = 2'd1,
        LK_RUN   = 2'd2
    } lock_st_t;

    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_UP   = 2'd1,
        LEG_DN   = 2'd2
    } leg_st_t;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_UP   = 2'd1,
        SIDE_DN   = 2'd2
    } side_t;

    localparam logic [1:0] OUT_Z    = 2'b00;
    localparam logic [1:0] OUT_LOW  = 2'b01;
    localparam logic [1:0] OUT_HIGH = 2'b10;

endpackage

// File: rtl/hbg_pulse_qual.sv
module hbg_pulse_qual #(
    parameter int MIN_PW = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    output logic qual
);
    localparam int W = $clog2(MIN_PW + 1);
    localparam logic [W-1:0] LIMIT = W'(MIN_PW);

    logic [W-1:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (!cmd) begin
            width_q <= '0;
        end else if (width_q != LIMIT) begin
            width_q <= width_q + 1'b1;
        end
    end

    assign qual = (width_q == LIMIT);

endmodule

// File: rtl/hbg_lock.sv
module hbg_lock
    import hbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_in,
    input  logic cmd_any,
    output logic gate_en
);
    logic [1:0] sync_q;
    logic       halt_s;
    lock_st_t   st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], halt_in};
        end
    end

    assign halt_s = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= LK_HALT;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            LK_HALT:  if (!halt_s) st_nxt = LK_DRAIN;
            LK_DRAIN: begin
                if (halt_s)        st_nxt = LK_HALT;
                else if (!cmd_any) st_nxt = LK_RUN;
            end
            LK_RUN:   if (halt_s)  st_nxt = LK_HALT;
            default:               st_nxt = LK_HALT;
        endcase
    end

    // raw halt and both sync stages mask the gates until the lock itself sees halt
    always_comb begin
        gate_en = (st == LK_RUN) && !halt_in && (sync_q == 2'b00);
    end

    // R6
    halt_not_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_HALT) |=> (st != LK_RUN));

    // R6
    drain_waits_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_DRAIN && cmd_any) |=> (st != LK_RUN));

    // R5
    halt_kills_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_s |=> !gate_en);

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int MIN_PW = 19,
    parameter int DEAD   = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cmd_up,
    input  logic       cmd_dn,
    output logic       gate_up,
    output logic       gate_dn,
    output logic [1:0] leg_state
);
    localparam int DW = $clog2(DEAD + 1);
    localparam logic [DW-1:0] DEAD_W = DW'(DEAD);
    localparam int PW = $clog2(MIN_PW + 1);
    localparam logic [PW-1:0] MPW_W = PW'(MIN_PW);

    logic [1:0]    cmd_v;
    logic [1:0]    qual_v;
    leg_st_t       st, st_nxt;
    side_t         last_q;
    logic [DW-1:0] off_cnt;
    logic          gap_ok;
    logic          up_go, dn_go;

    assign cmd_v = {cmd_dn, cmd_up};

    for (genvar i = 0; i < 2; i++) begin : g_qual
        hbg_pulse_qual #(.MIN_PW(MIN_PW)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .cmd  (cmd_v[i]),
            .qual (qual_v[i])
        );
    end

    assign gap_ok = (off_cnt == DEAD_W);
    assign up_go  = en && qual_v[0] && cmd_up && !cmd_dn && (last_q != SIDE_DN || gap_ok);
    assign dn_go  = en && qual_v[1] && cmd_dn && !cmd_up && (last_q != SIDE_UP || gap_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= LEG_IDLE;
            last_q  <= SIDE_NONE;
            off_cnt <= DEAD_W;
        end else begin
            st <= st_nxt;
            if (st != LEG_IDLE && st_nxt == LEG_IDLE) begin
                off_cnt <= '0;
                last_q  <= (st == LEG_UP) ? SIDE_UP : SIDE_DN;
            end else if (st == LEG_IDLE && !gap_ok) begin
                off_cnt <= off_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            LEG_IDLE: begin
                if (up_go)      st_nxt = LEG_UP;
                else if (dn_go) st_nxt = LEG_DN;
            end
            LEG_UP:  if (!en || !cmd_up || cmd_dn) st_nxt = LEG_IDLE;
            LEG_DN:  if (!en || !cmd_dn || cmd_up) st_nxt = LEG_IDLE;
            default: st_nxt = LEG_IDLE;
        endcase
    end

    always_comb begin
        gate_up = (st == LEG_UP) && en && cmd_up && !cmd_dn;
        gate_dn = (st == LEG_DN) && en && cmd_dn && !cmd_up;
        if (gate_up)      leg_state = OUT_HIGH;
        else if (gate_dn) leg_state = OUT_LOW;
        else              leg_state = OUT_Z;
    end

    // checker state: cycles each gate's partner has been off, commands' high run
    logic [DW-1:0] gap_up, gap_dn;
    logic [PW-1:0] run_up, run_dn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_up <= DEAD_W;
            gap_dn <= DEAD_W;
            run_up <= '0;
            run_dn <= '0;
        end else begin
            gap_up <= gate_dn ? '0 : ((gap_up == DEAD_W) ? gap_up : gap_up + 1'b1);
            gap_dn <= gate_up ? '0 : ((gap_dn == DEAD_W) ? gap_dn : gap_dn + 1'b1);
            run_up <= !cmd_up ? '0 : ((run_up == MPW_W) ? run_up : run_up + 1'b1);
            run_dn <= !cmd_dn ? '0 : ((run_dn == MPW_W) ? run_dn : run_dn + 1'b1);
        end
    end

    // R3
    pair_conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_up && cmd_dn) |-> (!gate_up && !gate_dn && leg_state == OUT_Z));

    // R4
    pair_idle_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_up && !cmd_dn) |-> (leg_state == OUT_Z));

    // R8
    dead_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_up) |-> (gap_up == DEAD_W));

    // R8
    dead_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_dn) |-> (gap_dn == DEAD_W));

    // R9
    width_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_up) |-> (run_up == MPW_W));

    // R9
    width_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_dn) |-> (run_dn == MPW_W));

endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int MIN_PW_CYC = 19,
    parameter int DEAD_CYC   = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_in,
    input  logic       cmd_up_a,
    input  logic       cmd_dn_a,
    input  logic       cmd_up_b,
    input  logic       cmd_dn_b,
    output logic       gate_up_a,
    output logic       gate_dn_a,
    output logic       gate_up_b,
    output logic       gate_dn_b,
    output logic [1:0] leg_a_state,
    output logic [1:0] leg_b_state
);
    localparam int NPH = 2;

    logic             gate_en;
    logic [NPH-1:0]   up_v, dn_v, gup_v, gdn_v;
    logic [1:0]       st_v [NPH];

    assign up_v = {cmd_up_b, cmd_up_a};
    assign dn_v = {cmd_dn_b, cmd_dn_a};

    hbg_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt_in(halt_in),
        .cmd_any(|{up_v, dn_v}),
        .gate_en(gate_en)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        hbg_leg #(.MIN_PW(MIN_PW_CYC), .DEAD(DEAD_CYC)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (gate_en),
            .cmd_up   (up_v[p]),
            .cmd_dn   (dn_v[p]),
            .gate_up  (gup_v[p]),
            .gate_dn  (gdn_v[p]),
            .leg_state(st_v[p])
        );
    end

    assign gate_up_a   = gup_v[0];
    assign gate_dn_a   = gdn_v[0];
    assign gate_up_b   = gup_v[1];
    assign gate_dn_b   = gdn_v[1];
    assign leg_a_state = st_v[0];
    assign leg_b_state = st_v[1];

    // R5
    halt_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in |-> !(gate_up_a || gate_dn_a || gate_up_b || gate_dn_b));

endmodule

// File: tb/hbridge_guard_bench.sv
module hbridge_guard_bench;
    localparam int MPW = 3;
    localparam int DT  = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic halt_in = 0;
    logic ua = 0, la = 0, ub = 0, lb = 0;
    logic gua, gla, gub, glb;
    logic [1:0] sa, sb;
    int total = 0;
    int bad = 0;
    logic seen_ub = 0;

    always #4 clk = ~clk;

    hbridge_guard #(.MIN_PW_CYC(MPW), .DEAD_CYC(DT)) u_hbridge_guard (
        .clk(clk), .rst_n(rst_n), .halt_in(halt_in),
        .cmd_up_a(ua), .cmd_dn_a(la), .cmd_up_b(ub), .cmd_dn_b(lb),
        .gate_up_a(gua), .gate_dn_a(gla), .gate_up_b(gub), .gate_dn_b(glb),
        .leg_a_state(sa), .leg_b_state(sb)
    );

    always @(gub) if (gub) seen_ub = 1'b1;

    task automatic check(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_cmd(input logic [3:0] v);
        @(negedge clk);
        {ua, la, ub, lb} = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // edges until the chosen gate is seen on, counted from the drive at the last negedge
    task automatic count_on(input int which, output int n);
        n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            if ((which == 0 && gua) || (which == 1 && gla) ||
                (which == 2 && gub) || (which == 3 && glb)) begin
                n = k;
                break;
            end
        end
    endtask

    function automatic int leg_exp(input logic u, input logic d);
        if (u && !d) return 2;
        if (d && !u) return 1;
        return 0;
    endfunction

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        // R7: reset holds everything off even with a command high
        ua = 1;
        idle(3);
        check("R7 reset gates", {gua, gla, gub, glb}, 0);
        check("R7 reset state", {sa, sb}, 0);
        @(negedge clk); rst_n = 1;
        idle(10);
        check("R7 no release with command high", {gua, gla, gub, glb}, 0);
        set_cmd(4'b0000);
        idle(8);

        // R1 R2 R3 R4 sweep of all command patterns
        for (int v = 0; v < 16; v++) begin
            logic [3:0] c;
            c = 4'(v);
            set_cmd(4'b0000);
            idle(DT + 4);
            set_cmd(c);
            idle(MPW + DT + 4);
            check("R1/R2/R3/R4 leg A", sa, leg_exp(c[3], c[2]));
            check("R1/R2/R3/R4 leg B", sb, leg_exp(c[1], c[0]));
            check("R1 gate up A", gua, int'(c[3] && !c[2]));
            check("R2 gate dn B", glb, int'(c[0] && !c[1]));
        end

        // R9 latency from idle
        set_cmd(4'b0000); idle(DT + 4);
        set_cmd(4'b1000);
        count_on(0, n);
        check("R9 turn-on latency", n, MPW + 1);

        // R10 immediate turn-off
        @(negedge clk); ua = 0; #1;
        check("R10 gate off same cycle", gua, 0);

        // R3 conflict while on
        set_cmd(4'b1000); idle(MPW + 4);
        check("R1 up A on", sa, 2);
        @(negedge clk); la = 1; #1;
        check("R3 conflict off same cycle", {gua, gla}, 0);
        check("R3 conflict state Z", sa, 0);
        idle(5);
        check("R3 conflict held", sa, 0);

        // R8 swap in one cycle
        set_cmd(4'b0100); idle(MPW + DT + 4);
        check("R2 dn A on", sa, 1);
        set_cmd(4'b1000);
        count_on(0, n);
        check("R8 swap latency", n, (MPW + 1 > DT + 2) ? MPW + 1 : DT + 2);
        // R8 same side returns without dead time
        set_cmd(4'b0000);
        set_cmd(4'b1000);
        count_on(0, n);
        check("R8 same side latency", n, MPW + 1);

        // R9 pulse width sweep on up B
        for (int w = 1; w <= MPW + 2; w++) begin
            set_cmd(4'b0000); idle(DT + 4);
            seen_ub = 0;
            set_cmd(4'b0010);
            idle(w);
            ub = 0;
            idle(6);
            check("R9 pulse activity", seen_ub, int'(w >= MPW + 1));
        end

        // R5 shutdown
        set_cmd(4'b1001); idle(MPW + DT + 4);
        check("R1/R2 both legs on", {sa, sb}, 6'h0 | {2'b10, 2'b01});
        @(negedge clk); halt_in = 1; #1;
        check("R5 halt immediate", {gua, gla, gub, glb}, 0);
        for (int v = 1; v < 16; v += 5) begin
            set_cmd(4'(v)); idle(MPW + 4);
            check("R5 commands ignored", {gua, gla, gub, glb}, 0);
        end
        // R6 release blocked while a command stays high
        set_cmd(4'b1000);
        halt_in = 0;
        idle(12);
        check("R6 held command no enable", {gua, gla, gub, glb}, 0);
        set_cmd(4'b0000); idle(8);
        set_cmd(4'b0001);
        count_on(3, n);
        check("R6 fresh edge after release", n, MPW + 1);

        // R5 one-cycle halt latches
        set_cmd(4'b1000); idle(MPW + 4);
        @(negedge clk); halt_in = 1;
        @(negedge clk); halt_in = 0;
        idle(10);
        check("R5 short halt latched", {gua, gla, gub, glb}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule